// File: doc/BRIEF.md
# Handshaked Fall-Through FIFO with Occupancy Flags

This block is a 64-word, 9-bit first-in first-out buffer. Each side has a pulse-and-level handshake instead of a clocked enable. The writer raises a shift-in strobe to hand over a word and drops it to commit that word. The block answers with an input-ready level. The reader sees an output-ready level when a word sits on the data outputs. It pulses a shift-out strobe to take the word: raising the strobe withdraws the word, and lowering it advances to the next one. Both strobes are plain levels synchronous to the block clock. The block finds their edges internally.

A word written into an empty buffer falls through to the outputs by itself. A slot freed in a full buffer bubbles back to the input by itself. When the far-side strobe is already held high, as it is when two such buffers are chained, the ready signal rises only for a short pulse of `PULSE_CYC` clock cycles. That pulse performs the transfer. Two occupancy flags are decoded from the word count: an "almost-full or almost-empty" flag and a half-full flag. The count includes the word presented on the outputs.

The 8-bit build has an output-disable input, which drops the pad drive enable of the data outputs. A synchronous master reset empties the buffer.

Top module: `hs_fifo`

## Requirements
- R1: A rising shift_in while in_ready is high captures din, and in_ready goes low while shift_in stays high. After shift_in falls, in_ready returns high unless that write filled the buffer.
- R2: Words leave on dout in the order in which they were written.
- R3: With 64 words held, in_ready stays low and shift_in pulses store nothing. The extra word never appears on dout.
- R4: A rising shift_out while out_ready is high drops out_ready, and dout keeps the old word. After shift_out falls, the next word appears on dout with out_ready high.
- R5: With the buffer empty, shift_out pulses are ignored, out_ready stays low, and dout keeps the last word read.
- R6: A word written into an empty buffer while shift_out is low appears on dout. out_ready then stays high until shift_out next rises.
- R7: A word written into an empty buffer while shift_out is held high raises out_ready for exactly PULSE_CYC (default 2) cycles, then out_ready drops with the word still on dout. Later words wait until shift_out falls, which consumes the first word and presents the next.
- R8: When a read frees a slot in a full buffer and shift_in is low, in_ready rises and stays high. When shift_in is held high, in_ready is high for exactly PULSE_CYC cycles, din is captured at the end of that pulse, and the write commits when shift_in falls.
- R9: The count is completed writes minus completed reads. half_full is high when the count is 32 or more. almost_fe is high when the count is 56 or more, or 8 or fewer.
- R10: During master reset: out_ready low, in_ready high, dout all zero, almost_fe high, half_full low.
- R11: If shift_in is high when master reset is released, din is written and in_ready stays low until shift_in falls. That word then reaches dout.
- R12: With HAS_OE=1, out_disable high drives dout_en low and out_disable low drives it high. With HAS_OE=0, dout_en is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| mreset | input | 1 | Synchronous master reset, active high |
| din | input | W | Write data |
| shift_in | input | 1 | Write strobe level |
| in_ready | output | 1 | Buffer can take a word |
| dout | output | W | Presented read data |
| shift_out | input | 1 | Read strobe level |
| out_ready | output | 1 | dout holds a valid word |
| out_disable | input | 1 | Requests high impedance on the data pads (HAS_OE=1 only) |
| dout_en | output | 1 | Pad drive enable for dout |
| almost_fe | output | 1 | Count at or above 56, or at or below 8 |
| half_full | output | 1 | Count at or above 32 |

## Verification
The hardest case to reach is the bubblethrough pulse: a read from a full buffer while the writer holds shift_in high. Reaching it needs 64 committed writes, each a full strobe, and then a strobe that is raised while in_ready is low so that the block ignores it. The bench fills the buffer through single-word write tasks, checking both flags after every word. It then parks shift_in high with a marker word on din and performs one read. It counts the in_ready cycles in a fixed window and drains the buffer to prove that the marker landed last. The fallthrough pulse is reached the same way from an empty buffer with shift_out parked high.

// File: rtl/hs_fifo.sv
module hs_fifo #(
  parameter int W         = 9,
  parameter int DEPTH     = 64,
  parameter int PULSE_CYC = 2,
  parameter int AE_LVL    = 8,
  parameter int AF_LVL    = DEPTH - 8,
  parameter bit HAS_OE    = 1'b0
) (
  input  logic         clk,
  input  logic         mreset,
  input  logic [W-1:0] din,
  input  logic         shift_in,
  output logic         in_ready,
  output logic [W-1:0] dout,
  input  logic         shift_out,
  output logic         out_ready,
  input  logic         out_disable,
  output logic         dout_en,
  output logic         almost_fe,
  output logic         half_full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] FULL_L = CW'(DEPTH);
  localparam logic [CW-1:0] HF_L   = CW'(DEPTH / 2);
  localparam logic [CW-1:0] AF_L   = CW'(AF_LVL);
  localparam logic [CW-1:0] AE_L   = CW'(AE_LVL);
  localparam logic [AW-1:0] LAST_P = AW'(DEPTH - 1);
  localparam logic [TW-1:0] PUL_L  = TW'(PULSE_CYC);
  localparam logic [TW-1:0] ONE_T  = TW'(1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          si_q, so_q, ir_q, or_q, wr_pend, rd_pend;
  logic [TW-1:0] ir_tmr, or_tmr;
  logic [W-1:0]  dout_q;

  wire si_rise = shift_in & ~si_q;
  wire si_fall = ~shift_in & si_q;
  wire so_rise = shift_out & ~so_q;
  wire so_fall = ~shift_out & so_q;
  wire ir_end  = (ir_tmr == ONE_T) & shift_in;
  wire or_end  = (or_tmr == ONE_T) & shift_out;
  wire wr_cap  = (si_rise & ir_q) | ir_end;
  wire wr_done = si_fall & wr_pend;
  wire rd_req  = (so_rise & or_q) | or_end;
  wire rd_done = so_fall & rd_pend;

  always_ff @(posedge clk)
    if (wr_cap) mem[wptr] <= din;

  always_ff @(posedge clk) begin
    if (mreset) begin
      si_q <= 1'b0; so_q <= 1'b0;
      wptr <= '0; rptr <= '0; cnt <= '0;
      ir_q <= 1'b1; ir_tmr <= '0; wr_pend <= 1'b0;
      or_q <= 1'b0; or_tmr <= '0; rd_pend <= 1'b0;
      dout_q <= '0;
    end else begin
      si_q <= shift_in;
      so_q <= shift_out;
      cnt  <= cnt + CW'(wr_done) - CW'(rd_done);
      if (wr_done) wptr <= (wptr == LAST_P) ? '0 : wptr + AW'(1);
      if (rd_done) rptr <= (rptr == LAST_P) ? '0 : rptr + AW'(1);

      if (wr_cap) wr_pend <= 1'b1;
      else if (wr_done) wr_pend <= 1'b0;
      if (wr_cap) begin
        ir_q <= 1'b0; ir_tmr <= '0;
      end else if (!ir_q && !wr_pend && cnt < FULL_L) begin
        ir_q <= 1'b1; ir_tmr <= shift_in ? PUL_L : '0;
      end else if (ir_tmr != '0) begin
        ir_tmr <= shift_in ? ir_tmr - ONE_T : '0;
      end

      if (rd_req) rd_pend <= 1'b1;
      else if (rd_done) rd_pend <= 1'b0;
      if (rd_req) begin
        or_q <= 1'b0; or_tmr <= '0;
      end else if (!or_q && !rd_pend && cnt != '0) begin
        or_q <= 1'b1; dout_q <= mem[rptr];
        or_tmr <= shift_out ? PUL_L : '0;
      end else if (or_tmr != '0) begin
        or_tmr <= shift_out ? or_tmr - ONE_T : '0;
      end
    end
  end

  assign in_ready  = ir_q;
  assign out_ready = or_q;
  assign dout      = dout_q;
  assign dout_en   = HAS_OE ? ~out_disable : 1'b1;
  assign half_full = cnt >= HF_L;
  assign almost_fe = (cnt >= AF_L) || (cnt <= AE_L);

  AST_RST_STATE: assert property (@(posedge clk) $past(mreset) |-> (in_ready && !out_ready && dout == '0 && cnt == '0)); // R10
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (mreset) (cnt == FULL_L) |-> !in_ready); // R3
  AST_EMPTY_NO_OR: assert property (@(posedge clk) disable iff (mreset) (cnt == '0) |-> !out_ready); // R5
  AST_OR_DROP: assert property (@(posedge clk) disable iff (mreset) ($rose(shift_out) && out_ready) |=> !out_ready); // R4
  AST_DO_HOLD: assert property (@(posedge clk) disable iff (mreset) (out_ready && $past(out_ready)) |-> $stable(dout)); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (mreset) (cnt == $past(cnt)) || (cnt == $past(cnt) + CW'(1)) || ($past(cnt) == cnt + CW'(1))); // R9
endmodule

// File: tb/hs_fifo_test.sv
module hs_fifo_test;
  logic clk = 1'b0, mreset = 1'b1, si = 1'b0, so = 1'b0, out_dis = 1'b0;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic ir, orr, den, afe, hf;
  logic [7:0] dout8;
  logic ir8, or8, den8, afe8, hf8;
  int checks = 0, fails = 0;
  logic [8:0] q [256];
  int head = 0, tail = 0, mc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hs_fifo uut (.clk(clk), .mreset(mreset), .din(din), .shift_in(si), .in_ready(ir),
    .dout(dout), .shift_out(so), .out_ready(orr), .out_disable(out_dis), .dout_en(den),
    .almost_fe(afe), .half_full(hf));

  hs_fifo #(.W(8), .HAS_OE(1'b1)) uut_oe (.clk(clk), .mreset(mreset), .din(8'h00),
    .shift_in(1'b0), .in_ready(ir8), .dout(dout8), .shift_out(1'b0), .out_ready(or8),
    .out_disable(out_dis), .dout_en(den8), .almost_fe(afe8), .half_full(hf8));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_flags(input string tag);
    chk({tag, " R9 hf"}, int'(hf), int'(mc >= 32));
    chk({tag, " R9 afe"}, int'(afe), int'(mc >= 56 || mc <= 8));
  endtask

  task automatic do_reset(input logic si_lvl, input logic [8:0] d);
    @(negedge clk);
    mreset = 1'b1; si = si_lvl; din = d; so = 1'b0;
    cyc(3);
    chk("R10 or", int'(orr), 0);
    chk("R10 ir", int'(ir), 1);
    chk("R10 dout", int'(dout), 0);
    chk("R10 afe", int'(afe), 1);
    chk("R10 hf", int'(hf), 0);
    mreset = 1'b0; head = 0; tail = 0; mc = 0;
  endtask

  task automatic push(input logic [8:0] d);
    din = d; si = 1'b1;
    cyc(3);
    chk("R1 ir low while si high", int'(ir), 0);
    si = 1'b0; q[tail % 256] = d; tail++; mc++;
    cyc(3);
    chk("R1 ir after si fall", int'(ir), int'(mc < 64));
    chk_flags("push");
  endtask

  task automatic pop();
    chk("R2 or before read", int'(orr), 1);
    chk("R2 order", int'(dout), int'(q[head % 256]));
    so = 1'b1;
    cyc(3);
    chk("R4 or low after so rise", int'(orr), 0);
    chk("R4 dout held", int'(dout), int'(q[head % 256]));
    so = 1'b0; head++; mc--;
    cyc(3);
    chk("R4 or after so fall", int'(orr), int'(mc > 0));
    if (mc > 0) chk("R4 next word", int'(dout), int'(q[head % 256]));
    chk_flags("pop");
  endtask

  task automatic t_basic();
    do_reset(1'b0, 9'h0);
    push(9'h011); push(9'h122); push(9'h033);
    pop(); pop(); pop();
  endtask

  task automatic t_empty();
    so = 1'b1; cyc(3); so = 1'b0; cyc(3);
    chk("R5 or stays low", int'(orr), 0);
    chk("R5 last word held", int'(dout), 9'h033);
  endtask

  task automatic t_fall_solow();
    push(9'h0a5);
    cyc(10);
    chk("R6 or held high", int'(orr), 1);
    chk("R6 word on dout", int'(dout), 9'h0a5);
    pop();
  endtask

  task automatic t_fall_sohigh();
    int hi = 0;
    so = 1'b1; cyc(2);
    din = 9'h1c3; si = 1'b1; cyc(3); si = 1'b0;
    q[tail % 256] = 9'h1c3; tail++; mc++;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (orr) hi++;
    end
    chk("R7 or pulse width", hi, 2);
    chk("R7 word held", int'(dout), 9'h1c3);
    push(9'h04e);
    chk("R7 queued word hidden", int'(dout), 9'h1c3);
    chk("R7 or low", int'(orr), 0);
    so = 1'b0; head++; mc--;
    cyc(3);
    chk("R7 next after so fall", int'(dout), 9'h04e);
    chk("R7 or high", int'(orr), 1);
    pop();
  endtask

  task automatic t_full();
    int hi = 0;
    for (int i = 0; i < 64; i++) push(9'(i * 7 + 3));
    chk("R3 full ir", int'(ir), 0);
    din = 9'h1ff; si = 1'b1; cyc(3); si = 1'b0; cyc(3);
    chk("R3 ir stays low", int'(ir), 0);
    chk_flags("R3 full");
    pop();
    cyc(10);
    chk("R8 ir stays high si low", int'(ir), 1);
    push(9'h0f0);
    chk("R8 full again", int'(ir), 0);
    din = 9'h15a; si = 1'b1; cyc(3);
    chk("R8 ir low before read", int'(ir), 0);
    chk("R8 head", int'(dout), int'(q[head % 256]));
    so = 1'b1; cyc(3); so = 1'b0; head++; mc--;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (ir) hi++;
    end
    chk("R8 ir pulse width", hi, 2);
    si = 1'b0; q[tail % 256] = 9'h15a; tail++; mc++;
    cyc(3);
    chk("R8 full after bubble", int'(ir), 0);
    while (mc > 0) pop();
    chk("R3 extra word absent", int'(orr), 0);
    chk("R8 last word", int'(dout), 9'h15a);
  endtask

  task automatic t_reset_si_high();
    do_reset(1'b1, 9'h155);
    cyc(3);
    chk("R11 ir low", int'(ir), 0);
    si = 1'b0; q[tail % 256] = 9'h155; tail++; mc++;
    cyc(4);
    chk("R11 word out", int'(dout), 9'h155);
    chk("R11 or", int'(orr), 1);
    pop();
  endtask

  task automatic t_oe();
    out_dis = 1'b1; cyc(1);
    chk("R12 oe build disabled", int'(den8), 0);
    chk("R12 no-oe build", int'(den), 1);
    out_dis = 1'b0; cyc(1);
    chk("R12 oe build enabled", int'(den8), 1);
  endtask

  initial begin
    t_basic();
    t_empty();
    t_fall_solow();
    t_fall_sohigh();
    t_full();
    t_reset_si_high();
    t_oe();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule